// File: doc/BRIEF.md
# Periodic Battery Health Test Sequencer

This block decides when a backup battery is put under a test load and keeps an active-low battery warning up to date. While the main supply is reported valid it runs a load test at a fixed start-to-start interval; during each test it raises a load-connect enable for a fixed number of clock cycles. In the last cycle of that pulse it looks at an external comparator that reports whether the battery voltage is above the trip point.

The warning behaves differently for the two kinds of test. A scheduled test can only raise the warning, and once raised it stays raised through later scheduled tests. Every time the supply comes back, the block runs a retest straight away. That retest writes the warning in either direction, so a replaced or recovered battery clears it. When the supply fails, the load enable drops in the same cycle, all counting stops, and the schedule restarts from the next power-up retest. The interval and pulse lengths are given in clock cycles, so a slow system tick can stand for real-time hours and seconds. `INTERVAL_CYCLES` must be larger than `PULSE_CYCLES`.

Top module: `batt_test_seq`

## Requirements
- R1: While `rstN` is low, `loadEn` is 0 and `battWarnN` is 1 (no warning).
- R2: When `supplyOk` is sampled high at a clock edge while the block is idle with no supply, `loadEn` goes high after that edge and stays high for exactly `PULSE_CYCLES` cycles (the power-up retest).
- R3: The comparator input `battAboveTrip` is used only at the clock edge that ends a load pulse. Its value in the earlier cycles of the pulse has no effect on `battWarnN`.
- R4: A power-up retest writes the warning. `battWarnN` becomes 0 if `battAboveTrip` is 0 and becomes 1 if it is 1, at the edge that ends the pulse. This happens no more than `PULSE_CYCLES`+1 cycles after `supplyOk` is first sampled high.
- R5: While `supplyOk` stays high, scheduled tests start every `INTERVAL_CYCLES` cycles, measured from start to start. The first scheduled test starts `INTERVAL_CYCLES` cycles after the power-up retest starts. Between tests, `loadEn` is low for `INTERVAL_CYCLES`-`PULSE_CYCLES` cycles.
- R6: A scheduled test that reads `battAboveTrip`=0 sets the warning (`battWarnN`=0). A scheduled test that reads 1 leaves `battWarnN` unchanged, so it never clears the warning.
- R7: When `supplyOk` is low, `loadEn` is 0 in the same cycle, with no clock edge needed. No test starts while it stays low, and the interval count restarts from the next power-up retest.
- R8: `battWarnN` keeps its value while `supplyOk` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| supplyOk | input | 1 | Main supply is within tolerance |
| battAboveTrip | input | 1 | Comparator: battery voltage is above the trip point |
| loadEn | output | 1 | Connects the battery test load |
| battWarnN | output | 1 | Battery warning, active low |

## Verification
A wrong sequencer state shows up first at `loadEn`. The pulse can run long or short by a cycle. The gap between pulses can be off by a cycle. A power-up can fail to bring a pulse within one cycle. Each of these is measured to the exact cycle against the schedule in R2 and R5. A wrong warning register or a wrong update rule shows up at `battWarnN` on the edge that ends a pulse. The bench checks `battWarnN` there under four conditions: a comparator value that changes inside the pulse, a good reading after a bad one on a scheduled test, a good reading on a power-up retest, and a power loss with the warning active.

// File: rtl/bt_pkg.sv
package bt_pkg;

  // Sequencer phases
  typedef enum logic [1:0] {
    ST_OFF   = 2'd0,  // supply not valid, everything parked
    ST_PTEST = 2'd1,  // power-up retest pulse
    ST_WAIT  = 2'd2,  // idle gap between tests
    ST_ITEST = 2'd3   // scheduled test pulse
  } btState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic runPulse;  // advance the pulse counter, else hold it at zero
    logic runGap;    // advance the gap counter, else hold it at zero
    logic setWarn;   // raise the warning
    logic clrWarn;   // drop the warning
  } btStrobe_t;

endpackage

// File: rtl/bt_datapath.sv
module bt_datapath
  import bt_pkg::*;
#(
  parameter int unsigned PULSE_CYCLES = 1000,
  parameter int unsigned GAP_CYCLES   = 1000
) (
  input  logic      clk,
  input  logic      rstN,
  input  btStrobe_t strobe,
  output logic      pulseLast,
  output logic      gapLast,
  output logic      warnActive
);

  localparam int unsigned PW = $clog2(PULSE_CYCLES + 1);
  localparam int unsigned GW = $clog2(GAP_CYCLES + 1);
  localparam logic [PW-1:0] PULSE_END = PW'(PULSE_CYCLES - 1);
  localparam logic [GW-1:0] GAP_END   = GW'(GAP_CYCLES - 1);

  logic [PW-1:0] pulseCnt;
  logic [GW-1:0] gapCnt;

  assign pulseLast = (pulseCnt == PULSE_END);
  assign gapLast   = (gapCnt == GAP_END);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pulseCnt <= '0;
    end else if (!strobe.runPulse || pulseLast) begin
      pulseCnt <= '0;
    end else begin
      pulseCnt <= pulseCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gapCnt <= '0;
    end else if (!strobe.runGap || gapLast) begin
      gapCnt <= '0;
    end else begin
      gapCnt <= gapCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      warnActive <= 1'b0;
    end else if (strobe.setWarn) begin
      warnActive <= 1'b1;
    end else if (strobe.clrWarn) begin
      warnActive <= 1'b0;
    end
  end

  // R3
  warn_only_at_pulse_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(warnActive) |-> $past(pulseLast && strobe.runPulse));

endmodule

// File: rtl/bt_ctrl.sv
module bt_ctrl
  import bt_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      supplyOk,
  input  logic      battAboveTrip,
  input  logic      pulseLast,
  input  logic      gapLast,
  input  logic      warnIn,
  output btStrobe_t strobe,
  output logic      testActive
);

  btState_t state, stateNxt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_OFF;
    else       state <= stateNxt;
  end

  always_comb begin
    stateNxt = state;
    strobe   = '0;
    if (!supplyOk) begin
      stateNxt = ST_OFF;
    end else begin
      unique case (state)
        ST_OFF: stateNxt = ST_PTEST;
        ST_PTEST: begin
          strobe.runPulse = 1'b1;
          if (pulseLast) begin
            stateNxt       = ST_WAIT;
            strobe.setWarn = !battAboveTrip;
            strobe.clrWarn = battAboveTrip;
          end
        end
        ST_WAIT: begin
          strobe.runGap = 1'b1;
          if (gapLast) stateNxt = ST_ITEST;
        end
        ST_ITEST: begin
          strobe.runPulse = 1'b1;
          if (pulseLast) begin
            stateNxt       = ST_WAIT;
            strobe.setWarn = !battAboveTrip;
          end
        end
        default: stateNxt = ST_OFF;
      endcase
    end
  end

  assign testActive = (state == ST_PTEST) || (state == ST_ITEST);

  // R6
  sched_no_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ITEST) |=> !$fell(warnIn));

  // R2
  retest_on_powerup_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(supplyOk) |=> (state == ST_PTEST));

endmodule

// File: rtl/batt_test_seq.sv
module batt_test_seq
  import bt_pkg::*;
#(
  parameter int unsigned INTERVAL_CYCLES = 86_400_000,
  parameter int unsigned PULSE_CYCLES    = 1000
) (
  input  logic clk,
  input  logic rstN,
  input  logic supplyOk,
  input  logic battAboveTrip,
  output logic loadEn,
  output logic battWarnN
);

  localparam int unsigned GAP_CYCLES = INTERVAL_CYCLES - PULSE_CYCLES;

  btStrobe_t strobe;
  logic      pulseLast;
  logic      gapLast;
  logic      warnActive;
  logic      testActive;

  bt_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .supplyOk     (supplyOk),
    .battAboveTrip(battAboveTrip),
    .pulseLast    (pulseLast),
    .gapLast      (gapLast),
    .warnIn       (warnActive),
    .strobe       (strobe),
    .testActive   (testActive)
  );

  bt_datapath #(
    .PULSE_CYCLES(PULSE_CYCLES),
    .GAP_CYCLES  (GAP_CYCLES)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .pulseLast (pulseLast),
    .gapLast   (gapLast),
    .warnActive(warnActive)
  );

  // Load disconnects the moment the supply is lost
  assign loadEn    = testActive && supplyOk;
  assign battWarnN = !warnActive;

  // R7
  no_load_after_fail_chk: assert property (@(posedge clk) disable iff (!rstN)
    !supplyOk |=> !loadEn);

  // R8
  warn_kept_unpowered_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!supplyOk && !$past(supplyOk)) |-> $stable(battWarnN));

endmodule

// File: tb/batt_test_seq_tb.sv
module batt_test_seq_tb;

  localparam int unsigned P = 8;
  localparam int unsigned I = 40;

  logic clk = 1'b0;
  logic rstN;
  logic supplyOk;
  logic battAboveTrip;
  logic loadEn;
  logic battWarnN;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #2.5 clk = ~clk;

  batt_test_seq #(.INTERVAL_CYCLES(I), .PULSE_CYCLES(P)) u_dut (
    .clk(clk), .rstN(rstN), .supplyOk(supplyOk),
    .battAboveTrip(battAboveTrip), .loadEn(loadEn), .battWarnN(battWarnN)
  );

  task automatic check(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // At the first negedge with loadEn high: drive early value for all but the
  // last pulse cycle, lastVal in the cycle that ends the pulse.
  task automatic runPulse(input string req, input logic early, input logic lastVal);
    int highs = 0;
    for (int i = 1; i <= int'(P); i++) begin
      battAboveTrip = (i == int'(P)) ? lastVal : early;
      if (loadEn) highs++;
      @(negedge clk);
    end
    check({req, " pulse length"}, highs, P);
    check({req, " load off after pulse"}, loadEn, 0);
  endtask

  // Count low samples until loadEn rises, starting at the current negedge
  task automatic measureGap(input string req);
    int lows = 0;
    while (!loadEn && lows < 4 * int'(I)) begin
      lows++;
      @(negedge clk);
    end
    check(req, lows, I - P);
  endtask

  task automatic powerUp();
    supplyOk = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_reset();
    rstN = 1'b0; supplyOk = 1'b0; battAboveTrip = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 loadEn in reset", loadEn, 0);
    check("R1 battWarnN in reset", battWarnN, 1);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_goodPowerUp();
    powerUp();
    check("R2 pulse starts one edge after supply", loadEn, 1);
    runPulse("R2", 1'b0, 1'b1);
    check("R3 early low reading ignored", battWarnN, 1);
    check("R4 good retest leaves no warning", battWarnN, 1);
  endtask

  task automatic t_schedule();
    measureGap("R5 gap before first scheduled test");
    runPulse("R5", 1'b1, 1'b0);
    check("R6 scheduled bad reading sets warning", battWarnN, 0);
    measureGap("R5 gap between scheduled tests");
    runPulse("R5", 1'b1, 1'b1);
    check("R6 scheduled good reading keeps warning", battWarnN, 0);
  endtask

  task automatic t_powerFail();
    int seen = 0;
    measureGap("R5 gap before interrupted test");
    @(negedge clk);
    @(negedge clk);
    supplyOk = 1'b0;
    #1;
    check("R7 load drops with supply, same cycle", loadEn, 0);
    for (int i = 0; i < 3 * int'(I); i++) begin
      battAboveTrip = i[0];
      @(negedge clk);
      if (loadEn) seen++;
    end
    check("R7 no test while supply low", seen, 0);
    check("R8 warning kept while unpowered", battWarnN, 0);
  endtask

  task automatic t_retestClears();
    powerUp();
    check("R2 retest pulse starts", loadEn, 1);
    runPulse("R4", 1'b0, 1'b1);
    check("R4 power-up retest clears warning", battWarnN, 1);
  endtask

  task automatic t_midGapRestart();
    repeat (10) @(negedge clk);
    supplyOk = 1'b0;
    repeat (3) @(negedge clk);
    powerUp();
    check("R7 power-up after mid-gap loss tests at once", loadEn, 1);
    runPulse("R4", 1'b1, 1'b0);
    check("R4 power-up retest sets warning", battWarnN, 0);
    measureGap("R7 interval restarted after power-up");
    runPulse("R6", 1'b0, 1'b1);
    check("R6 still latched after good scheduled test", battWarnN, 0);
  endtask

  initial begin
    t_reset();
    t_goodPowerUp();
    t_schedule();
    t_powerFail();
    t_retestClears();
    t_midGapRestart();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  end

endmodule